// File: doc/BRIEF.md
# Segmented Function Evaluator

This unit evaluates a small set of elementary functions on a signed Q8.8 operand (16 bits, 8 of them fractional). A select code picks one of seven table functions: exponential, natural logarithm, square root, hyperbolic tangent, logistic sigmoid, sine or cosine. It can also pick one of four exact functions: absolute value, clamp between two bounds, maximum or minimum.

Each table function is a constant 16-entry table that is fixed in the logic. The operand is first limited to the window [-8.0, +8.0). That window is split into sixteen segments, each one unit wide. Every operand inside a segment returns the same stored value, which is the function at the segment centre. The exact functions use comparators and multiplexers only.

The unit suits neuron-model datapaths that need a cheap nonlinearity. By default the result is registered, so it appears one clock after the operands.

Top module: `seg_func_unit`

## Requirements
- R1: With the default output register, `result` shows the function of the inputs sampled at the previous rising edge. An asynchronous active-low reset forces `result` to 0, and it stays 0 while reset is held.
- R2: For the table functions the operand is clamped to [-2048, 2047] raw (-8.0 to just below +8.0). The segment is floor(x)+8, in the range 0..15. Segment k covers [k-8, k-7), and every operand inside one segment gives the same result.
- R3: Select 0 is exp. Each entry is round(256·e^(k-7.5)), saturated to 32767. Examples: segment 8 gives 422, segment 7 gives 155, segments 13 to 15 give 32767, segment 0 gives 0.
- R4: Select 1 is log. Segments 0 to 7, whose centres are negative, give -32768. Segment 8 gives -177 and segment 11 gives 321.
- R5: Select 2 is sqrt. Segments 0 to 7 give 0 and segment 10 gives 405.
- R6: Select 3 is tanh and select 4 is sigmoid. Tanh lies in [-256, 256] (segment 12 gives 256, segment 5 gives -253). Sigmoid lies in [0, 256] (segment 8 gives 159, segment 7 gives 97).
- R7: Select 5 is sin and select 6 is cos. Sin: segment 0 gives -240, segment 1 gives -55, segment 15 gives 240. Cos: segment 9 gives 18, segment 4 gives -240.
- R8: Select 7 returns |op_a| exactly. The one exception is -32768, which saturates to 32767.
- R9: Select 8 clamps op_a between clip_lo and clip_hi. If op_a < clip_lo the result is clip_lo; otherwise, if op_a > clip_hi, it is clip_hi; otherwise it is op_a. The lower bound therefore wins when the bounds are crossed.
- R10: Select 9 returns the signed maximum of op_a and op_b.
- R11: Select 10 returns the signed minimum of op_a and op_b.
- R12: Select codes 11 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_sel | input | 4 | Function select code |
| op_a | input | 16 | Main signed Q8.8 operand |
| op_b | input | 16 | Second operand for max and min |
| clip_lo | input | 16 | Lower clamp bound |
| clip_hi | input | 16 | Upper clamp bound |
| result | output | 16 | Signed Q8.8 result |

## Verification
Every result, whether from a table or an exact function, is due exactly one rising edge after its operands are presented. The bench therefore drives operands on a falling edge and compares on the next falling edge. One directed step changes the operands and checks shortly afterwards that the output still holds the previous value, which confirms the single register stage. The reset checks are made while reset is held, and again immediately after it is asserted mid-run, because the reset does not wait for a clock edge.

// File: rtl/seg_func_unit.sv
module seg_func_unit #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         func_sel,
  input  logic signed [15:0] op_a,
  input  logic signed [15:0] op_b,
  input  logic signed [15:0] clip_lo,
  input  logic signed [15:0] clip_hi,
  output logic signed [15:0] result
);

  localparam logic signed [15:0] QMAX = 16'sh7FFF;
  localparam logic signed [15:0] QMIN = -16'sh8000;
  localparam logic signed [15:0] WIN_LO = -16'sd2048;
  localparam logic signed [15:0] WIN_HI = 16'sd2047;

  localparam logic [3:0] F_EXP = 4'd0, F_LOG = 4'd1, F_SQRT = 4'd2, F_TANH = 4'd3,
                         F_SIG = 4'd4, F_SIN = 4'd5, F_COS = 4'd6, F_ABS = 4'd7,
                         F_CLIP = 4'd8, F_MAX = 4'd9, F_MIN = 4'd10;

  function automatic logic signed [15:0] t_exp(input logic [3:0] k);
    case (k)
      4'd0, 4'd1: t_exp = 16'sd0;
      4'd2:  t_exp = 16'sd1;
      4'd3:  t_exp = 16'sd3;
      4'd4:  t_exp = 16'sd8;
      4'd5:  t_exp = 16'sd21;
      4'd6:  t_exp = 16'sd57;
      4'd7:  t_exp = 16'sd155;
      4'd8:  t_exp = 16'sd422;
      4'd9:  t_exp = 16'sd1147;
      4'd10: t_exp = 16'sd3119;
      4'd11: t_exp = 16'sd8478;
      4'd12: t_exp = 16'sd23044;
      default: t_exp = QMAX;
    endcase
  endfunction

  function automatic logic signed [15:0] t_log(input logic [3:0] k);
    case (k)
      4'd8:  t_log = -16'sd177;
      4'd9:  t_log = 16'sd104;
      4'd10: t_log = 16'sd235;
      4'd11: t_log = 16'sd321;
      4'd12: t_log = 16'sd385;
      4'd13: t_log = 16'sd436;
      4'd14: t_log = 16'sd479;
      4'd15: t_log = 16'sd516;
      default: t_log = QMIN;
    endcase
  endfunction

  function automatic logic signed [15:0] t_sqrt(input logic [3:0] k);
    case (k)
      4'd8:  t_sqrt = 16'sd181;
      4'd9:  t_sqrt = 16'sd314;
      4'd10: t_sqrt = 16'sd405;
      4'd11: t_sqrt = 16'sd479;
      4'd12: t_sqrt = 16'sd543;
      4'd13: t_sqrt = 16'sd600;
      4'd14: t_sqrt = 16'sd653;
      4'd15: t_sqrt = 16'sd701;
      default: t_sqrt = 16'sd0;
    endcase
  endfunction

  function automatic logic signed [15:0] t_tanh(input logic [3:0] k);
    case (k)
      4'd5:  t_tanh = -16'sd253;
      4'd6:  t_tanh = -16'sd232;
      4'd7:  t_tanh = -16'sd118;
      4'd8:  t_tanh = 16'sd118;
      4'd9:  t_tanh = 16'sd232;
      4'd10: t_tanh = 16'sd253;
      4'd11, 4'd12, 4'd13, 4'd14, 4'd15: t_tanh = 16'sd256;
      default: t_tanh = -16'sd256;
    endcase
  endfunction

  function automatic logic signed [15:0] t_sig(input logic [3:0] k);
    case (k)
      4'd2:  t_sig = 16'sd1;
      4'd3:  t_sig = 16'sd3;
      4'd4:  t_sig = 16'sd8;
      4'd5:  t_sig = 16'sd19;
      4'd6:  t_sig = 16'sd47;
      4'd7:  t_sig = 16'sd97;
      4'd8:  t_sig = 16'sd159;
      4'd9:  t_sig = 16'sd209;
      4'd10: t_sig = 16'sd237;
      4'd11: t_sig = 16'sd248;
      4'd12: t_sig = 16'sd253;
      4'd13: t_sig = 16'sd255;
      4'd14, 4'd15: t_sig = 16'sd256;
      default: t_sig = 16'sd0;
    endcase
  endfunction

  function automatic logic signed [15:0] t_sin(input logic [3:0] k);
    case (k)
      4'd0:  t_sin = -16'sd240;
      4'd1:  t_sin = -16'sd55;
      4'd2:  t_sin = 16'sd181;
      4'd3:  t_sin = 16'sd250;
      4'd4:  t_sin = 16'sd90;
      4'd5:  t_sin = -16'sd153;
      4'd6:  t_sin = -16'sd255;
      4'd7:  t_sin = -16'sd123;
      4'd8:  t_sin = 16'sd123;
      4'd9:  t_sin = 16'sd255;
      4'd10: t_sin = 16'sd153;
      4'd11: t_sin = -16'sd90;
      4'd12: t_sin = -16'sd250;
      4'd13: t_sin = -16'sd181;
      4'd14: t_sin = 16'sd55;
      default: t_sin = 16'sd240;
    endcase
  endfunction

  function automatic logic signed [15:0] t_cos(input logic [3:0] k);
    case (k)
      4'd0, 4'd15: t_cos = 16'sd89;
      4'd1, 4'd14: t_cos = 16'sd250;
      4'd2, 4'd13: t_cos = 16'sd181;
      4'd3, 4'd12: t_cos = -16'sd54;
      4'd4, 4'd11: t_cos = -16'sd240;
      4'd5, 4'd10: t_cos = -16'sd205;
      4'd6, 4'd9:  t_cos = 16'sd18;
      default:     t_cos = 16'sd225;
    endcase
  endfunction

  logic [3:0]         seg;
  logic signed [15:0] abs_a, clip_a, max_ab, min_ab, fn_val;

  assign seg = (op_a < WIN_LO) ? 4'd0 :
               (op_a > WIN_HI) ? 4'd15 : {~op_a[11], op_a[10:8]};

  assign abs_a  = (op_a == QMIN) ? QMAX : (op_a < 0) ? -op_a : op_a;
  assign clip_a = (op_a < clip_lo) ? clip_lo : (op_a > clip_hi) ? clip_hi : op_a;
  assign max_ab = (op_a > op_b) ? op_a : op_b;
  assign min_ab = (op_a < op_b) ? op_a : op_b;

  always_comb begin
    case (func_sel)
      F_EXP:   fn_val = t_exp(seg);
      F_LOG:   fn_val = t_log(seg);
      F_SQRT:  fn_val = t_sqrt(seg);
      F_TANH:  fn_val = t_tanh(seg);
      F_SIG:   fn_val = t_sig(seg);
      F_SIN:   fn_val = t_sin(seg);
      F_COS:   fn_val = t_cos(seg);
      F_ABS:   fn_val = abs_a;
      F_CLIP:  fn_val = clip_a;
      F_MAX:   fn_val = max_ab;
      F_MIN:   fn_val = min_ab;
      default: fn_val = 16'sd0;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) result <= 16'sd0;
        else        result <= fn_val;

      a_r8_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == F_ABS) |-> result >= 0);
      a_r9_clip_inside: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == F_CLIP && $past(clip_lo) <= $past(clip_hi))
        |-> (result >= $past(clip_lo) && result <= $past(clip_hi)));
      a_r10_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == F_MAX)
        |-> (result >= $past(op_a) && result >= $past(op_b)));
      a_r11_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == F_MIN)
        |-> (result <= $past(op_a) && result <= $past(op_b)));
      a_r6_tanh_range: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == F_TANH)
        |-> (result >= -16'sd256 && result <= 16'sd256));
      a_r5_sqrt_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == F_SQRT) |-> result >= 0);
      a_r12_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) > F_MIN) |-> result == 0);
    end else begin : g_comb
      assign result = fn_val;
    end
  endgenerate

endmodule

// File: tb/sim_seg_func_unit.sv
module sim_seg_func_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] func_sel = 4'd7;
  logic signed [15:0] op_a = -16'sd4660, op_b = '0, clip_lo = '0, clip_hi = '0;
  logic signed [15:0] result;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  seg_func_unit u0 (.clk(clk), .rst_n(rst_n), .func_sel(func_sel), .op_a(op_a),
                    .op_b(op_b), .clip_lo(clip_lo), .clip_hi(clip_hi), .result(result));

  localparam int NV = 36;
  localparam logic [3:0] VS [NV] = '{
    4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0,
    4'd5, 4'd5, 4'd5, 4'd5, 4'd5,
    4'd1, 4'd1, 4'd1, 4'd2, 4'd2,
    4'd3, 4'd3, 4'd4, 4'd4, 4'd6, 4'd6,
    4'd7, 4'd7, 4'd7, 4'd8, 4'd8, 4'd8,
    4'd9, 4'd9, 4'd10, 4'd10, 4'd11, 4'd15, 4'd8};
  localparam logic signed [15:0] VA [NV] = '{
    16'sd0, 16'sd255, -16'sd256, 16'sd1280, 16'sd32767, -16'sd32768, 16'sd2048,
    -16'sd2049, -16'sd2048, -16'sd2047, -16'sd1792, 16'sd32767,
    16'sd0, -16'sd1, 16'sd768, 16'sd512, -16'sd256,
    16'sd1024, -16'sd640, 16'sd0, -16'sd256, 16'sd256, -16'sd896,
    -16'sd4660, -16'sd32768, 16'sd256, 16'sd768, -16'sd1280, 16'sd128,
    -16'sd5, 16'sd28672, -16'sd5, 16'sd100, 16'sd1234, -16'sd1234, 16'sd0};
  localparam logic signed [15:0] VB [NV] = '{
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd3, -16'sd28672, 16'sd3, 16'sd100, 16'sd0, 16'sd0, 16'sd0};
  localparam logic signed [15:0] VL [NV] = '{
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, -16'sd256, -16'sd256, -16'sd256,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd256};
  localparam logic signed [15:0] VH [NV] = '{
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd256, 16'sd256, 16'sd256,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, -16'sd256};
  localparam logic signed [15:0] VE [NV] = '{
    16'sd422, 16'sd422, 16'sd155, 16'sd32767, 16'sd32767, 16'sd0, 16'sd32767,
    -16'sd240, -16'sd240, -16'sd240, -16'sd55, 16'sd240,
    -16'sd177, -16'sd32768, 16'sd321, 16'sd405, 16'sd0,
    16'sd256, -16'sd253, 16'sd159, 16'sd97, 16'sd18, -16'sd240,
    16'sd4660, 16'sd32767, 16'sd256, 16'sd256, -16'sd256, 16'sd128,
    16'sd3, 16'sd28672, -16'sd5, 16'sd100, 16'sd0, 16'sd0, 16'sd256};
  // Requirement per vector: R3 exp, R2 segment/clamp, R4 log, R5 sqrt, R6 tanh/sigmoid,
  // R7 sin/cos, R8 abs, R9 clip, R10 max, R11 min, R12 unused codes
  localparam int VR [NV] = '{
    3, 2, 3, 3, 2, 2, 2,
    2, 2, 2, 2, 2,
    4, 4, 4, 5, 5,
    6, 6, 6, 6, 7, 7,
    8, 8, 8, 9, 9, 9,
    10, 10, 11, 11, 12, 12, 9};

  task automatic check(input string tag, input logic signed [15:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s: result=%0d expected=%0d", tag, result, exp);
    end
  endtask

  task automatic drive(input logic [3:0] s, input logic signed [15:0] a, b, lo, hi);
    func_sel = s; op_a = a; op_b = b; clip_lo = lo; clip_hi = hi;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: result=%0d expected=completion", result);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", 16'sd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VS[i], VA[i], VB[i], VL[i], VH[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VR[i], i), VE[i]);
    end

    // R1: one register stage, old value held until the next edge
    @(negedge clk);
    drive(4'd9, 16'sd3, -16'sd5, 16'sd0, 16'sd0);
    @(negedge clk);
    check("R1 latency max", 16'sd3);
    drive(4'd10, 16'sd3, -16'sd5, 16'sd0, 16'sd0);
    #1;
    check("R1 hold before edge", 16'sd3);
    @(negedge clk);
    check("R1 next result min", -16'sd5);

    // R2: both ends of one segment give the same entry (segment 9, tanh 232)
    drive(4'd3, 16'sd256, 16'sd0, 16'sd0, 16'sd0);
    @(negedge clk);
    check("R2 segment start", 16'sd232);
    drive(4'd3, 16'sd511, 16'sd0, 16'sd0, 16'sd0);
    @(negedge clk);
    check("R2 segment end", 16'sd232);

    // R1: asynchronous reset mid-run
    drive(4'd7, -16'sd100, 16'sd0, 16'sd0, 16'sd0);
    @(negedge clk);
    check("R8 abs before reset", 16'sd100);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 16'sd0);
    @(negedge clk);
    check("R1 reset held with input", 16'sd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 16'sd100);

    finish_run();
  end
endmodule